// File: doc/BRIEF.md
# FIFO Status and Interrupt-Clear Register

This block is one 8-bit register of a serial peripheral that owns an 8-entry transmit FIFO and an 8-entry receive FIFO. It keeps the occupancy level of each FIFO from push and pop strobes. It drops any push that arrives while a FIFO is full and records that as an overflow. When a level has been corrupted beyond the FIFO depth, it flushes that FIFO and records a count error. The four condition flags are read through a simple synchronous register bus and clear on read.

The low nibble of the same register is a write-one strobe field. It produces one-cycle clear pulses for four interrupt sources kept elsewhere in the peripheral. The pulses are produced only while an interrupt-clear enable held in a separate control register is set. A test input can load an arbitrary 4-bit level into either counter, so that the count-error path can be reached.

Top module: `fifo_flag_reg`

## Requirements
- R1: While reset is applied, and on the first cycles after it, both levels, all four flags, the read data, the interrupt-clear pulses and both flush outputs are 0.
- R2: A read at the register address (default 9) returns the flags one cycle later on `bus_rdata`: bit 7 transmit count error, bit 6 receive count error, bit 5 transmit overflow, bit 4 receive overflow. Bits 3..0 read 0. A read at any other address, or no read, gives `bus_rdata` = 0 and clears nothing.
- R3: A receive push while the receive level equals 8 is not accepted (`rx_accept` = 0), leaves the level unchanged and sets the receive overflow flag (bit 4).
- R4: A transmit push while the transmit level equals 8 is not accepted (`tx_accept` = 0), leaves the level unchanged and sets the transmit overflow flag (bit 5).
- R5: A register read clears every flag that was 1 when the read was sampled. An overflow that is detected in the same cycle as the read leaves its flag at 1 after the read.
- R6: When a level is above 8, on the next cycle that level is 0 and its flush output is 1 for exactly one cycle. All four flags are reset, and only the count-error flag of each corrupted FIFO is set (transmit bit 7, receive bit 6).
- R7: A write at the register address with `clr_enable` = 1 drives `irq_clear` = `bus_wdata[3:0]` for one cycle, starting the cycle after the write. Bit 3 is transmit nearly empty, bit 2 receive nearly full, bit 1 transmit empty and bit 0 receive full. With `clr_enable` = 0, or no write, `irq_clear` stays 0.
- R8: Writes have no effect on the four flags, whatever the value of `bus_wdata[7:4]`.
- R9: An accepted push increments a level and a pop at a level from 1 to 8 decrements it; both together leave it unchanged. A pop at level 0 is ignored. `tx_full`/`rx_full` is 1 exactly when the level is 8 or more.
- R10: `test_force_tx`/`test_force_rx` loads `test_level` into that level on the next cycle. While the force is applied, push and pop have no effect on that level and the push is not accepted. A flush caused by a level above 8 takes precedence over the force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | ADDR_W | Register bus address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| clr_enable | input | 1 | Interrupt-clear enable from the control register |
| irq_clear | output | 4 | One-cycle interrupt clear pulses |
| tx_push | input | 1 | Data register write toward the transmit FIFO |
| tx_pop | input | 1 | Transmit FIFO entry consumed by the shifter |
| rx_push | input | 1 | Received frame toward the receive FIFO |
| rx_pop | input | 1 | Receive FIFO entry read out |
| tx_accept | output | 1 | Transmit push is stored |
| rx_accept | output | 1 | Receive push is stored |
| tx_full | output | 1 | Transmit level at or above depth |
| rx_full | output | 1 | Receive level at or above depth |
| tx_level | output | CNT_W | Transmit occupancy |
| rx_level | output | CNT_W | Receive occupancy |
| tx_flush | output | 1 | Transmit FIFO flush pulse |
| rx_flush | output | 1 | Receive FIFO flush pulse |
| test_force_tx | input | 1 | Load `test_level` into the transmit level |
| test_force_rx | input | 1 | Load `test_level` into the receive level |
| test_level | input | CNT_W | Level value to force |

## Verification
Two sets of events can fall in the same cycle. A register read can coincide with a new overflow, and a read can coincide with a corrupted level that forces a flush. The bench provokes the first by holding a FIFO full and issuing a read together with another push. It provokes the second by forcing a level of 12 and reading on the following cycle. In both cases the read data must show the flags as they stood before the edge. After the edge, the new overflow flag must still be set, or the flags must hold only the count-error bit. Random traffic with frequent reads near full adds further collisions, and a cycle model in the bench judges every cycle.

// File: rtl/ffr_pkg.sv
package ffr_pkg;
  localparam int unsigned REG_W   = 8;
  localparam int unsigned NUM_IRQ = 4;
  localparam int unsigned NUM_CH  = 2;
  localparam int unsigned CH_TX   = 0;
  localparam int unsigned CH_RX   = 1;

  // Flag order matches the read image, bit 7 down to bit 4.
  typedef struct packed {
    logic tx_err;
    logic rx_err;
    logic tx_ovf;
    logic rx_ovf;
  } stat_flags_t;

  function automatic logic [REG_W-1:0] pack_image(input stat_flags_t f);
    return {f, {NUM_IRQ{1'b0}}};
  endfunction
endpackage

// File: rtl/ffr_rst_sync.sv
module ffr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/ffr_occ_track.sv
module ffr_occ_track #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic             force_ld,
  input  logic [CNT_W-1:0] force_val,
  output logic [CNT_W-1:0] level,
  output logic             full,
  output logic             accept,
  output logic             overflow,
  output logic             corrupt,
  output logic             flush
);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] ONE_C   = CNT_W'(1);

  logic [CNT_W-1:0] lvl_q, lvl_d;
  logic             flush_q, flush_d;
  logic             room, take, give;

  always_comb begin
    corrupt  = (lvl_q > DEPTH_C);
    room     = (lvl_q < DEPTH_C);
    take     = push && room && !force_ld;
    give     = pop && (lvl_q != '0) && !corrupt && !force_ld;
    overflow = push && !room;
    lvl_d    = lvl_q;
    flush_d  = 1'b0;
    if (corrupt) begin
      lvl_d   = '0;
      flush_d = 1'b1;
    end else if (force_ld) begin
      lvl_d = force_val;
    end else if (take && !give) begin
      lvl_d = lvl_q + ONE_C;
    end else if (give && !take) begin
      lvl_d = lvl_q - ONE_C;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q   <= '0;
      flush_q <= 1'b0;
    end else begin
      lvl_q   <= lvl_d;
      flush_q <= flush_d;
    end
  end

  assign level  = lvl_q;
  assign full   = !room;
  assign accept = take;
  assign flush  = flush_q;
endmodule

// File: rtl/ffr_flag_bank.sv
module ffr_flag_bank
  import ffr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ovf_tx,
  input  logic        ovf_rx,
  input  logic        err_tx,
  input  logic        err_rx,
  input  logic        rd_clr,
  output stat_flags_t flags
);
  stat_flags_t flags_q, flags_d, drop, raise;

  always_comb begin
    drop  = rd_clr ? flags_q : '0;
    raise = '{tx_err: 1'b0, rx_err: 1'b0, tx_ovf: ovf_tx, rx_ovf: ovf_rx};
    if (err_tx || err_rx) begin
      flags_d = '{tx_err: err_tx, rx_err: err_rx, tx_ovf: 1'b0, rx_ovf: 1'b0};
    end else begin
      flags_d = (flags_q & ~drop) | raise;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assign flags = flags_q;
endmodule

// File: rtl/ffr_bus_port.sv
module ffr_bus_port
  import ffr_pkg::*;
#(
  parameter int unsigned      ADDR_W   = 4,
  parameter logic [ADDR_W-1:0] REG_ADDR = 4'h9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               rd,
  input  logic               wr,
  input  logic [REG_W-1:0]   wdata,
  input  logic               clr_enable,
  input  logic [REG_W-1:0]   image,
  output logic               rd_hit,
  output logic [REG_W-1:0]   rdata,
  output logic [NUM_IRQ-1:0] irq_clear
);
  logic               hit;
  logic [REG_W-1:0]   rdata_q, rdata_d;
  logic [NUM_IRQ-1:0] irq_q, irq_d;
  logic               unused_wdata_hi;

  // Upper write bits address read-only flags and are discarded.
  assign unused_wdata_hi = ^wdata[REG_W-1:NUM_IRQ];

  always_comb begin
    hit     = (addr == REG_ADDR);
    rd_hit  = rd && hit;
    rdata_d = rd_hit ? image : '0;
    irq_d   = (wr && hit && clr_enable) ? wdata[NUM_IRQ-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      irq_q   <= '0;
    end else begin
      rdata_q <= rdata_d;
      irq_q   <= irq_d;
    end
  end

  assign rdata     = rdata_q;
  assign irq_clear = irq_q;
endmodule

// File: rtl/fifo_flag_reg.sv
module fifo_flag_reg
  import ffr_pkg::*;
#(
  parameter int unsigned       DEPTH    = 8,
  parameter int unsigned       ADDR_W   = 4,
  parameter logic [ADDR_W-1:0] REG_ADDR = 4'h9,
  localparam int unsigned      CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_rd,
  input  logic               bus_wr,
  input  logic [REG_W-1:0]   bus_wdata,
  output logic [REG_W-1:0]   bus_rdata,
  input  logic               clr_enable,
  output logic [NUM_IRQ-1:0] irq_clear,
  input  logic               tx_push,
  input  logic               tx_pop,
  input  logic               rx_push,
  input  logic               rx_pop,
  output logic               tx_accept,
  output logic               rx_accept,
  output logic               tx_full,
  output logic               rx_full,
  output logic [CNT_W-1:0]   tx_level,
  output logic [CNT_W-1:0]   rx_level,
  output logic               tx_flush,
  output logic               rx_flush,
  input  logic               test_force_tx,
  input  logic               test_force_rx,
  input  logic [CNT_W-1:0]   test_level
);
  logic              rst_core_n;
  logic [NUM_CH-1:0] push_v, pop_v, force_v;
  logic [NUM_CH-1:0] full_v, acc_v, ovf_v, err_v, flush_v;
  logic [CNT_W-1:0]  lvl_v [NUM_CH];
  logic              rd_hit;
  stat_flags_t       stat_q;

  ffr_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  assign push_v[CH_TX]  = tx_push;
  assign push_v[CH_RX]  = rx_push;
  assign pop_v[CH_TX]   = tx_pop;
  assign pop_v[CH_RX]   = rx_pop;
  assign force_v[CH_TX] = test_force_tx;
  assign force_v[CH_RX] = test_force_rx;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    ffr_occ_track #(.DEPTH(DEPTH), .CNT_W(CNT_W)) i_occ (
      .clk       (clk),
      .rst_n     (rst_core_n),
      .push      (push_v[ch]),
      .pop       (pop_v[ch]),
      .force_ld  (force_v[ch]),
      .force_val (test_level),
      .level     (lvl_v[ch]),
      .full      (full_v[ch]),
      .accept    (acc_v[ch]),
      .overflow  (ovf_v[ch]),
      .corrupt   (err_v[ch]),
      .flush     (flush_v[ch])
    );
  end

  ffr_flag_bank i_flags (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .ovf_tx (ovf_v[CH_TX]),
    .ovf_rx (ovf_v[CH_RX]),
    .err_tx (err_v[CH_TX]),
    .err_rx (err_v[CH_RX]),
    .rd_clr (rd_hit),
    .flags  (stat_q)
  );

  ffr_bus_port #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) i_bus (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .addr       (bus_addr),
    .rd         (bus_rd),
    .wr         (bus_wr),
    .wdata      (bus_wdata),
    .clr_enable (clr_enable),
    .image      (pack_image(stat_q)),
    .rd_hit     (rd_hit),
    .rdata      (bus_rdata),
    .irq_clear  (irq_clear)
  );

  assign tx_accept = acc_v[CH_TX];
  assign rx_accept = acc_v[CH_RX];
  assign tx_full   = full_v[CH_TX];
  assign rx_full   = full_v[CH_RX];
  assign tx_level  = lvl_v[CH_TX];
  assign rx_level  = lvl_v[CH_RX];
  assign tx_flush  = flush_v[CH_TX];
  assign rx_flush  = flush_v[CH_RX];
endmodule

// File: rtl/ffr_checker.sv
module ffr_checker #(
  parameter int unsigned       DEPTH    = 8,
  parameter int unsigned       ADDR_W   = 4,
  parameter logic [ADDR_W-1:0] REG_ADDR = 4'h9,
  parameter int unsigned       CNT_W    = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic              clr_enable,
  input logic [7:0]        bus_rdata,
  input logic [3:0]        irq_clear,
  input logic              tx_push,
  input logic              rx_push,
  input logic              rx_pop,
  input logic              tx_full,
  input logic              rx_full,
  input logic              tx_accept,
  input logic              rx_accept,
  input logic [CNT_W-1:0]  tx_level,
  input logic [CNT_W-1:0]  rx_level,
  input logic              tx_flush,
  input logic              rx_flush,
  input logic              test_force_rx,
  input logic [CNT_W-1:0]  test_level,
  input logic [3:0]        flags
);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  // R2: no read hit means zero read data next cycle
  assert_idle_rdata_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_addr == REG_ADDR) |=> bus_rdata == 8'h00);

  // R3: receive push at full is refused, level held, flag raised
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push && rx_full |-> !rx_accept);
  assert_rx_ovf_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push && rx_level == DEPTH_C && tx_level <= DEPTH_C |=> flags[0]);

  // R4: transmit push at full is refused
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_push && tx_full |-> !tx_accept);

  // R5: read with no new event leaves every flag clear
  assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && bus_addr == REG_ADDR && !(tx_push && tx_full) && !(rx_push && rx_full)
    && tx_level <= DEPTH_C && rx_level <= DEPTH_C |=> flags == 4'b0000);

  // R6: corrupted level flushes once and sets only the error flag
  assert_rx_flush_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_level > DEPTH_C && tx_level <= DEPTH_C |=> rx_flush && rx_level == '0 && flags == 4'b0100);
  assert_tx_flush_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_level > DEPTH_C |=> tx_flush && tx_level == '0 && flags[3]);
  assert_flush_once_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flush |=> !rx_flush);

  // R7: no enabled write, no clear pulse
  assert_irq_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && clr_enable && bus_addr == REG_ADDR) |=> irq_clear == 4'b0000);

  // R9: plain accepted receive push adds one
  assert_rx_inc_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push && !rx_pop && !test_force_rx && rx_level < DEPTH_C |=> rx_level == $past(rx_level) + CNT_W'(1));

  // R10: force loads the test value
  assert_force_R10: assert property (@(posedge clk) disable iff (!rst_n)
    test_force_rx && rx_level <= DEPTH_C |=> rx_level == $past(test_level));
endmodule

bind fifo_flag_reg ffr_checker #(
  .DEPTH(DEPTH), .ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR), .CNT_W(CNT_W)
) i_ffr_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .bus_addr      (bus_addr),
  .bus_rd        (bus_rd),
  .bus_wr        (bus_wr),
  .clr_enable    (clr_enable),
  .bus_rdata     (bus_rdata),
  .irq_clear     (irq_clear),
  .tx_push       (tx_push),
  .rx_push       (rx_push),
  .rx_pop        (rx_pop),
  .tx_full       (tx_full),
  .rx_full       (rx_full),
  .tx_accept     (tx_accept),
  .rx_accept     (rx_accept),
  .tx_level      (tx_level),
  .rx_level      (rx_level),
  .tx_flush      (tx_flush),
  .rx_flush      (rx_flush),
  .test_force_rx (test_force_rx),
  .test_level    (test_level),
  .flags         (stat_q)
);

// File: tb/test_fifo_flag_reg.sv
`timescale 1ns/1ps
module test_fifo_flag_reg;
  localparam int unsigned DEPTH = 8;
  localparam logic [3:0]  RADDR = 4'h9;

  logic       clk, rst_n;
  logic [3:0] bus_addr;
  logic       bus_rd, bus_wr, clr_enable;
  logic [7:0] bus_wdata, bus_rdata;
  logic [3:0] irq_clear;
  logic       tx_push, tx_pop, rx_push, rx_pop;
  logic       tx_accept, rx_accept, tx_full, rx_full, tx_flush, rx_flush;
  logic [3:0] tx_level, rx_level, test_level;
  logic       test_force_tx, test_force_rx;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // bench model state
  logic [3:0] m_lvl [2];
  logic [3:0] m_flags;     // {tx_err, rx_err, tx_ovf, rx_ovf}
  logic [7:0] m_rdata;
  logic [3:0] m_irq;
  logic [1:0] m_flush;

  fifo_flag_reg i_fifo_flag_reg (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .clr_enable(clr_enable),
    .irq_clear(irq_clear), .tx_push(tx_push), .tx_pop(tx_pop), .rx_push(rx_push),
    .rx_pop(rx_pop), .tx_accept(tx_accept), .rx_accept(rx_accept), .tx_full(tx_full),
    .rx_full(rx_full), .tx_level(tx_level), .rx_level(rx_level), .tx_flush(tx_flush),
    .rx_flush(rx_flush), .test_force_tx(test_force_tx), .test_force_rx(test_force_rx),
    .test_level(test_level)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic exp_accept(input logic [3:0] lvl, input logic push, input logic frc);
    return push && (lvl < 4'(DEPTH)) && !frc;
  endfunction

  function automatic logic [3:0] exp_level(input logic [3:0] lvl, input logic push,
                                           input logic pop, input logic frc,
                                           input logic [3:0] fval);
    logic acc, gv;
    if (lvl > 4'(DEPTH)) return 4'd0;
    if (frc) return fval;
    acc = exp_accept(lvl, push, frc);
    gv  = pop && (lvl != 4'd0);
    return lvl + 4'(acc) - 4'(gv);
  endfunction

  // one cycle: drive at negedge, check combinational, advance, check registered
  task automatic step(input logic tp, input logic tpo, input logic rp, input logic rpo,
                      input logic rd, input logic wr, input logic [3:0] ad,
                      input logic [7:0] wd, input logic ce, input logic ftx,
                      input logic frx, input logic [3:0] fv);
    logic [3:0] n_lvl [2];
    logic [3:0] n_flags;
    logic e_tx, e_rx, o_tx, o_rx, hit;
    tx_push = tp; tx_pop = tpo; rx_push = rp; rx_pop = rpo;
    bus_rd = rd; bus_wr = wr; bus_addr = ad; bus_wdata = wd; clr_enable = ce;
    test_force_tx = ftx; test_force_rx = frx; test_level = fv;
    #1;
    check("R4 tx_accept", int'(tx_accept), int'(exp_accept(m_lvl[0], tp, ftx)));
    check("R3 rx_accept", int'(rx_accept), int'(exp_accept(m_lvl[1], rp, frx)));
    check("R9 tx_full", int'(tx_full), int'(m_lvl[0] >= 4'(DEPTH)));
    check("R9 rx_full", int'(rx_full), int'(m_lvl[1] >= 4'(DEPTH)));
    e_tx = m_lvl[0] > 4'(DEPTH);
    e_rx = m_lvl[1] > 4'(DEPTH);
    o_tx = tp && (m_lvl[0] >= 4'(DEPTH));
    o_rx = rp && (m_lvl[1] >= 4'(DEPTH));
    hit  = (ad == RADDR);
    n_lvl[0] = exp_level(m_lvl[0], tp, tpo, ftx, fv);
    n_lvl[1] = exp_level(m_lvl[1], rp, rpo, frx, fv);
    if (e_tx || e_rx) n_flags = {e_tx, e_rx, 2'b00};
    else n_flags = ((rd && hit) ? 4'b0000 : m_flags) | {2'b00, o_tx, o_rx};
    m_rdata = (rd && hit) ? {m_flags, 4'b0000} : 8'h00;
    m_irq   = (wr && hit && ce) ? wd[3:0] : 4'b0000;
    m_flush = {e_rx, e_tx};
    m_lvl[0] = n_lvl[0];
    m_lvl[1] = n_lvl[1];
    m_flags  = n_flags;
    @(negedge clk);
    check("R2/R5 rdata", int'(bus_rdata), int'(m_rdata));
    check("R7 irq_clear", int'(irq_clear), int'(m_irq));
    check("R9 tx_level", int'(tx_level), int'(m_lvl[0]));
    check("R9 rx_level", int'(rx_level), int'(m_lvl[1]));
    check("R6 tx_flush", int'(tx_flush), int'(m_flush[0]));
    check("R6 rx_flush", int'(rx_flush), int'(m_flush[1]));
  endtask

  task automatic idle();
    step(0,0,0,0, 0,0, 4'h0, 8'h00, 0, 0,0, 4'h0);
  endtask

  task automatic rd_reg();
    step(0,0,0,0, 1,0, RADDR, 8'h00, 0, 0,0, 4'h0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    {tx_push, tx_pop, rx_push, rx_pop, bus_rd, bus_wr, clr_enable} = '0;
    {test_force_tx, test_force_rx} = '0;
    bus_addr = '0; bus_wdata = '0; test_level = '0;
    m_lvl[0] = 0; m_lvl[1] = 0; m_flags = 0; m_rdata = 0; m_irq = 0; m_flush = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 rdata", int'(bus_rdata), 0);
    check("R1 levels", int'({tx_level, rx_level}), 0);
    check("R1 irq/flush", int'({irq_clear, tx_flush, rx_flush}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 after release", int'({bus_rdata, tx_level, rx_level}), 0);

    // R9: fill receive FIFO to depth
    for (int i = 0; i < DEPTH; i++) step(0,0,1,0, 0,0, 4'h0, 8'h00, 0, 0,0, 4'h0);
    check("R9 rx filled", int'(rx_level), DEPTH);
    // R3: push at full is dropped
    step(0,0,1,0, 0,0, 4'h0, 8'h00, 0, 0,0, 4'h0);
    check("R3 rx level held", int'(rx_level), DEPTH);
    // R4: fill transmit and overflow it
    for (int i = 0; i <= DEPTH; i++) step(1,0,0,0, 0,0, 4'h0, 8'h00, 0, 0,0, 4'h0);
    check("R4 tx level held", int'(tx_level), DEPTH);
    // R8: write with all upper bits set, flags unchanged
    step(0,0,0,0, 0,1, RADDR, 8'hF0, 1, 0,0, 4'h0);
    // R2: read image shows both overflow bits
    rd_reg();
    check("R2 image", int'(bus_rdata), 8'h30);
    check("R8 flags kept across write", int'(bus_rdata[7:4]), 4'h3);
    // R2: wrong address reads 0 and does not clear
    step(0,0,0,0, 1,0, 4'h3, 8'h00, 0, 0,0, 4'h0);
    check("R2 other addr", int'(bus_rdata), 0);
    // R5: cleared by the read above
    rd_reg();
    check("R5 cleared", int'(bus_rdata), 0);
    // R5: read collides with new receive overflow
    step(0,0,0,0, 1,0, RADDR, 8'h00, 0, 0,0, 4'h0);
    step(0,0,1,0, 1,0, RADDR, 8'h00, 0, 0,0, 4'h0);
    check("R5 collide read old", int'(bus_rdata), 0);
    rd_reg();
    check("R5 same-cycle set kept", int'(bus_rdata), 8'h10);
    // R7: gated clear pulses
    step(0,0,0,0, 0,1, RADDR, 8'hA5, 0, 0,0, 4'h0);
    check("R7 disabled", int'(irq_clear), 0);
    step(0,0,0,0, 0,1, RADDR, 8'hA5, 1, 0,0, 4'h0);
    check("R7 enabled", int'(irq_clear), 4'h5);
    idle();
    check("R7 one cycle", int'(irq_clear), 0);
    // R10 / R6: force receive level to 12, then read in the flush cycle
    step(1,0,0,0, 0,0, 4'h0, 8'h00, 0, 0,1, 4'd12);
    check("R10 forced", int'(rx_level), 12);
    step(1,0,0,0, 1,0, RADDR, 8'h00, 0, 0,0, 4'h0);
    check("R6 flushed", int'({rx_flush, rx_level}), 5'h10);
    rd_reg();
    check("R6 only rx error", int'(bus_rdata), 8'h40);
    // R10: flush wins over a force in the same cycle
    step(0,0,0,0, 0,0, 4'h0, 8'h00, 0, 1,0, 4'd9);
    step(0,0,0,0, 0,0, 4'h0, 8'h00, 0, 1,0, 4'd3);
    check("R10 flush precedence", int'(tx_level), 0);
    rd_reg();
    check("R6 tx error", int'(bus_rdata), 8'h80);

    // constrained random traffic with fixed seed
    void'($urandom(32'h5eed_1234));
    for (int n = 0; n < 4000; n++) begin
      logic frc;
      frc = ($urandom % 48) == 0;
      step(($urandom % 3) != 0, ($urandom % 4) == 0,
           ($urandom % 3) != 0, ($urandom % 4) == 0,
           ($urandom % 4) == 0, ($urandom % 6) == 0,
           (($urandom % 8) == 0) ? 4'($urandom) : RADDR,
           8'($urandom), 1'($urandom),
           frc && ($urandom % 2 == 0), frc && ($urandom % 2 == 1),
           4'($urandom));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule